// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block acts as the master that pushes a raw configuration image into a programmable logic device set up to take its configuration over a one-bit serial link. Image bytes arrive on a byte stream with valid/ready flow control plus start and end markers, which suits a DMA engine or any other streaming source. The block passes the image through without altering it.

The first beat of an image, tagged with the start marker, opens a load. The block pulls the active-low configuration request pin low for a set number of system clocks and then releases it. It waits, with a timeout, for the target's active-low status pin to go high. It then shifts every byte out least-significant bit first on the data pin, one bit for each rising edge of the serial clock. When the last bit has gone out, it keeps clocking while it polls the target's configuration-complete pin, and it reports done or error. A low level on the status pin during shifting or trailing aborts the load.

The serial clock half-period, the request pulse width, the status wait window, the trailing clock count and the trailing limit are all parameters. The status and complete inputs pass through a two-stage synchronizer before the control logic uses them.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset and while idle, the request pin is high, the serial clock is low, the data pin is low, and ready, busy, done and error are all low.
- R2: A beat that carries the start marker while idle begins a load. The request pin then goes low for exactly PULSE_CYC system clocks, once per load, and that same beat becomes the first image byte.
- R3: No serial clock edge occurs until the synchronized status pin reads high. If it stays low for STAT_WAIT clocks after the request pin is released, the block raises error and returns to idle without sending any data.
- R4: Each accepted byte is sent least-significant bit first, one bit for each serial clock rising edge, with bytes in the order they were accepted and no bit altered, added or dropped.
- R5: The data pin changes only while the serial clock is low, so it is stable at every rising edge.
- R6: The ready output is high only when the shift stage is empty during shifting. While no byte is available, the serial clock stays low.
- R7: A low status pin during shifting or trailing aborts the load: error is raised, busy drops, the request pin is high and the serial clock is low.
- R8: After the last image bit, if the complete pin is already high, the block issues exactly TRAIL_CLKS further rising edges, then raises done and returns to idle.
- R9: If the complete pin has not gone high by the time DONE_LIMIT trailing rising edges have been issued, the block raises error with no further edges.
- R10: A start marker on a beat during a load has no effect beyond the beat's data: no new request pulse is issued and the byte is sent as image data.
- R11: While idle, beats without the start marker are not accepted (ready stays low) and produce no pin activity.
- R12: Done and error are never high together. Both hold their value after a load ends and are cleared when the next load starts.
- R13: Successive serial clock rising edges are at least 2*CLK_DIV system clocks apart, and exactly that far apart within a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted when high together with s_valid |
| s_data | input | WORD_BITS | Image byte |
| s_first | input | 1 | Start marker, opens a load while idle |
| s_last | input | 1 | End marker on the final image byte |
| cfg_n_o | output | 1 | Active-low configuration request to the target |
| dclk_o | output | 1 | Serial configuration clock |
| data0_o | output | 1 | Serial configuration data |
| status_n_i | input | 1 | Active-low status from the target |
| cfg_done_i | input | 1 | Configuration-complete flag from the target |
| busy | output | 1 | A load is in progress |
| load_done | output | 1 | Last load completed successfully (held) |
| load_err | output | 1 | Last load ended in error (held) |

## Verification
The bench builds the loader with CLK_DIV=2, PULSE_CYC=8, STAT_WAIT=40, TRAIL_CLKS=4 and DONE_LIMIT=16. With these values the status timeout and the trailing limit are reached within tens of cycles, and a serial clock period of four system clocks makes the edge spacing and data hold windows measurable. A behavioural target model releases its status pin after a set delay, raises the complete flag after a set bit count, and can pull status low at a chosen bit. The bench rebuilds the image from the rising edges and counts request pulses, trailing edges and edge spacing.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_PULSE,
    LD_WAIT,
    LD_SHIFT,
    LD_TRAIL
  } ld_state_e;
endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             zero
);
  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - WIDTH'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ps_cfg_tick.sv
module ps_cfg_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/ps_cfg_shift.sv
module ps_cfg_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ld,
  input  logic [BITS-1:0] ld_word,
  input  logic            tick,
  input  logic            trail,
  output logic            dclk,
  output logic            data0,
  output logic            empty,
  output logic            fall,
  output logic            word_done
);
  localparam int RW = $clog2(BITS + 1);

  logic [BITS-1:0] sh;
  logic [RW-1:0]   rem;
  logic            active;

  assign active    = trail || (rem != '0);
  assign empty     = (rem == '0);
  assign fall      = tick && dclk && active;
  assign word_done = fall && !trail && (rem == RW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dclk  <= 1'b0;
      data0 <= 1'b0;
      rem   <= '0;
      sh    <= '0;
    end else if (ld && empty && !trail) begin
      // first bit is presented while the clock is low
      data0 <= ld_word[0];
      sh    <= ld_word >> 1;
      rem   <= RW'(BITS);
    end else if (tick && active) begin
      if (!dclk) begin
        dclk <= 1'b1;
      end else begin
        dclk <= 1'b0;
        if (trail) begin
          data0 <= 1'b0;
        end else begin
          data0 <= sh[0];
          sh    <= sh >> 1;
          rem   <= rem - RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader #(
  parameter int WORD_BITS  = 8,
  parameter int CLK_DIV    = 4,
  parameter int PULSE_CYC  = 16,
  parameter int STAT_WAIT  = 2000,
  parameter int TRAIL_CLKS = 8,
  parameter int DONE_LIMIT = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [WORD_BITS-1:0] s_data,
  input  logic                 s_first,
  input  logic                 s_last,
  output logic                 cfg_n_o,
  output logic                 dclk_o,
  output logic                 data0_o,
  input  logic                 status_n_i,
  input  logic                 cfg_done_i,
  output logic                 busy,
  output logic                 load_done,
  output logic                 load_err
);
  import ps_cfg_pkg::*;

  localparam int TMAX = (PULSE_CYC > STAT_WAIT) ? PULSE_CYC : STAT_WAIT;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(DONE_LIMIT + 1);

  ld_state_e state;
  logic      last_seen;
  logic [CW-1:0] trail_cnt;

  logic [1:0] sync_q;
  logic       stat_s, done_s;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  logic tick, sh_clr, sh_empty, sh_fall, sh_word_done, accept;
  logic trail_ok, trail_to;

  ps_cfg_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({status_n_i, cfg_done_i}),
    .q   (sync_q)
  );
  assign stat_s = sync_q[1];
  assign done_s = sync_q[0];

  ps_cfg_timer #(.WIDTH(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ps_cfg_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  ((state == LD_SHIFT) || (state == LD_TRAIL)),
    .tick (tick)
  );

  ps_cfg_shift #(.BITS(WORD_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .clr       (sh_clr),
    .ld        (accept),
    .ld_word   (s_data),
    .tick      (tick),
    .trail     (state == LD_TRAIL),
    .dclk      (dclk_o),
    .data0     (data0_o),
    .empty     (sh_empty),
    .fall      (sh_fall),
    .word_done (sh_word_done)
  );

  assign s_ready  = (state == LD_SHIFT) && sh_empty && !last_seen && stat_s;
  assign accept   = s_valid && s_ready;
  assign busy     = (state != LD_IDLE);
  assign trail_ok = !dclk_o && (trail_cnt >= CW'(TRAIL_CLKS)) && done_s;
  assign trail_to = (trail_cnt >= CW'(DONE_LIMIT));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_clr   = 1'b0;
    unique case (state)
      LD_IDLE: begin
        if (s_valid && s_first) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(PULSE_CYC - 1);
        end
      end
      LD_PULSE: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(STAT_WAIT);
        end
      end
      LD_WAIT:  ;
      LD_SHIFT: sh_clr = !stat_s;
      LD_TRAIL: sh_clr = !stat_s || trail_ok || trail_to;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LD_IDLE;
      cfg_n_o   <= 1'b1;
      load_done <= 1'b0;
      load_err  <= 1'b0;
      last_seen <= 1'b0;
      trail_cnt <= '0;
    end else begin
      unique case (state)
        LD_IDLE: begin
          if (s_valid && s_first) begin
            state     <= LD_PULSE;
            cfg_n_o   <= 1'b0;
            load_done <= 1'b0;
            load_err  <= 1'b0;
            last_seen <= 1'b0;
            trail_cnt <= '0;
          end
        end
        LD_PULSE: begin
          if (tmr_zero) begin
            cfg_n_o <= 1'b1;
            state   <= LD_WAIT;
          end
        end
        LD_WAIT: begin
          if (stat_s) begin
            state <= LD_SHIFT;
          end else if (tmr_zero) begin
            load_err <= 1'b1;
            state    <= LD_IDLE;
          end
        end
        LD_SHIFT: begin
          if (!stat_s) begin
            load_err <= 1'b1;
            state    <= LD_IDLE;
          end else begin
            if (accept && s_last) last_seen <= 1'b1;
            if (sh_word_done && last_seen) state <= LD_TRAIL;
          end
        end
        LD_TRAIL: begin
          if (!stat_s) begin
            load_err <= 1'b1;
            state    <= LD_IDLE;
          end else if (trail_ok) begin
            load_done <= 1'b1;
            state     <= LD_IDLE;
          end else if (trail_to) begin
            load_err <= 1'b1;
            state    <= LD_IDLE;
          end else if (sh_fall) begin
            trail_cnt <= trail_cnt + CW'(1);
          end
        end
        default: state <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk (
  input logic clk,
  input logic rst,
  input logic s_ready,
  input logic cfg_n_o,
  input logic dclk_o,
  input logic data0_o,
  input logic busy,
  input logic load_done,
  input logic load_err
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cfg_n_o && !dclk_o));

  assert_no_clk_in_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_n_o |-> (!dclk_o && busy));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (dclk_o && $past(dclk_o)) |-> (data0_o == $past(data0_o)));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(load_err) |-> (!busy && cfg_n_o && !dclk_o));

  assert_ready_busy_R11: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> busy);

  assert_flags_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(load_done && load_err));
endmodule

bind ps_cfg_loader ps_cfg_loader_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .s_ready   (s_ready),
  .cfg_n_o   (cfg_n_o),
  .dclk_o    (dclk_o),
  .data0_o   (data0_o),
  .busy      (busy),
  .load_done (load_done),
  .load_err  (load_err)
);

// File: tb/ps_cfg_loader_tb.sv
`timescale 1ns/1ps
module ps_cfg_loader_tb;
  localparam int CLK_DIV    = 2;
  localparam int PULSE_CYC  = 8;
  localparam int STAT_WAIT  = 40;
  localparam int TRAIL_CLKS = 4;
  localparam int DONE_LIMIT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, cfg_n_o, dclk_o, data0_o, busy, load_done, load_err;
  logic nstat = 1'b0, cdone = 1'b0;

  always #2.5 clk = ~clk;

  ps_cfg_loader #(
    .WORD_BITS(8), .CLK_DIV(CLK_DIV), .PULSE_CYC(PULSE_CYC),
    .STAT_WAIT(STAT_WAIT), .TRAIL_CLKS(TRAIL_CLKS), .DONE_LIMIT(DONE_LIMIT)
  ) u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_first(s_first), .s_last(s_last), .cfg_n_o(cfg_n_o), .dclk_o(dclk_o),
    .data0_o(data0_o), .status_n_i(nstat), .cfg_done_i(cdone), .busy(busy),
    .load_done(load_done), .load_err(load_err)
  );

  int checks = 0, fails = 0;
  // target model settings and observations
  int rel_dly, need_bits, drop_at;
  int st_cnt, bitcnt, rises, viol, falls, low_len, last_low, cyc, last_rise, min_gap;
  int busy_done, rdy_dclk;
  bit prev_dclk, prev_data, prev_ncfg = 1'b1;
  logic [7:0] cap [16];
  logic [7:0] img [16];

  always @(negedge clk) begin
    cyc++;
    if (!cfg_n_o) begin
      if (prev_ncfg) falls++;
      low_len++;
      st_cnt = 0; nstat = 1'b0; cdone = 1'b0; bitcnt = 0;
    end else begin
      if (!prev_ncfg) begin last_low = low_len; low_len = 0; end
      if (st_cnt < rel_dly) st_cnt++;
      else nstat = 1'b1;
      if (dclk_o && !prev_dclk) begin
        if (bitcnt < 128) cap[bitcnt/8][bitcnt%8] = data0_o;
        bitcnt++; rises++;
        if (last_rise >= 0 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
        last_rise = cyc;
      end
      if (need_bits != 0 && bitcnt >= need_bits) cdone = 1'b1;
      if (drop_at != 0 && bitcnt >= drop_at) nstat = 1'b0;
    end
    if (dclk_o && prev_dclk && (data0_o != prev_data)) viol++;
    if (busy && load_done) busy_done++;
    if (s_ready && dclk_o) rdy_dclk++;
    prev_dclk = dclk_o; prev_data = data0_o; prev_ncfg = cfg_n_o;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_obs();
    rises = 0; viol = 0; falls = 0; last_rise = -1; min_gap = 1000;
    busy_done = 0; rdy_dclk = 0;
  endtask

  task automatic do_reset(input int rdly, input int nbits, input int drop);
    s_valid = 0; s_first = 0; s_last = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    rel_dly = rdly; need_bits = nbits; drop_at = drop;
    st_cnt = 0; bitcnt = 0; low_len = 0; last_low = 0;
    clear_obs();
    @(negedge clk) rst = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic run_load(input int n, input int mid, input int gap, output bit aborted);
    aborted = 0;
    for (int i = 0; i < n; i++) begin
      bit acc = 0;
      @(negedge clk);
      s_data = img[i]; s_first = (i == 0) || (i == mid); s_last = (i == n - 1); s_valid = 1'b1;
      for (int k = 0; k < 4000; k++) begin
        if (load_err && k > 0) break;
        if (s_ready) begin @(posedge clk); acc = 1; break; end
        @(negedge clk);
      end
      if (!acc) begin aborted = 1; s_valid = 1'b0; break; end
      if (gap > 0) begin
        @(negedge clk) s_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    @(negedge clk); s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk); #1;
  endtask

  function automatic int img_mism(input int n);
    int m = 0;
    for (int i = 0; i < n; i++) if (cap[i] !== img[i]) m++;
    return m;
  endfunction

  task automatic t_reset_idle();
    do_reset(5, 0, 0);
    chk("R1 request pin", cfg_n_o, 1);
    chk("R1 serial clock", dclk_o, 0);
    chk("R1 data pin", data0_o, 0);
    chk("R1 ready/busy", {s_ready, busy}, 0);
    chk("R1 done/err", {load_done, load_err}, 0);
    // R11: beats without a start marker while idle
    @(negedge clk); s_data = 8'hFF; s_first = 1'b0; s_valid = 1'b1;
    begin
      int rdy = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (s_ready) rdy++; end
      s_valid = 1'b0; #1;
      chk("R11 ready while idle", rdy, 0);
    end
    chk("R11 request pulses", falls, 0);
    chk("R11 clock edges", rises, 0);
    chk("R11 busy", busy, 0);
  endtask

  task automatic t_normal();
    bit ab;
    do_reset(5, 32, 0);
    img[0] = 8'hA5; img[1] = 8'h3C; img[2] = 8'h01; img[3] = 8'h80;
    run_load(4, -1, 0, ab);
    chk("R2 request pulse width", last_low, PULSE_CYC);
    chk("R2 request pulse count", falls, 1);
    chk("R4 image mismatches", img_mism(4), 0);
    chk("R5 data change while clock high", viol, 0);
    chk("R8 trailing edges", rises - 32, TRAIL_CLKS);
    chk("R8 done", load_done, 1);
    chk("R8 error", load_err, 0);
    chk("R13 min edge spacing", min_gap, 2 * CLK_DIV);
    repeat (10) @(negedge clk); #1;
    chk("R12 done held", load_done, 1);
  endtask

  task automatic t_back_to_back();
    bit ab;
    do_reset(5, 16, 0);
    img[0] = 8'h12; img[1] = 8'hEF;
    run_load(2, -1, 0, ab);
    chk("R12 first load done", load_done, 1);
    rises = 0; busy_done = 0; need_bits = 24;
    img[0] = 8'h00; img[1] = 8'hFF; img[2] = 8'h69;
    run_load(3, -1, 0, ab);
    chk("R12 done seen while busy", busy_done, 0);
    chk("R4 second image mismatches", img_mism(3), 0);
    chk("R12 second load done", load_done, 1);
    chk("R2 pulses over two loads", falls, 2);
  endtask

  task automatic t_stall();
    bit ab;
    do_reset(5, 24, 0);
    img[0] = 8'hC3; img[1] = 8'h5A; img[2] = 8'h7E;
    run_load(3, -1, 7, ab);
    chk("R6 image with gaps", img_mism(3), 0);
    chk("R6 clock high while ready", rdy_dclk, 0);
    chk("R6 done", load_done, 1);
  endtask

  task automatic t_status_timeout();
    bit ab;
    do_reset(100000, 0, 0);
    img[0] = 8'h11; img[1] = 8'h22;
    run_load(2, -1, 0, ab);
    chk("R3 error on status timeout", load_err, 1);
    chk("R3 no clock edges", rises, 0);
    chk("R3 done low", load_done, 0);
    chk("R3 back to idle", busy, 0);
  endtask

  task automatic t_drop();
    bit ab;
    do_reset(5, 0, 10);
    img[0] = 8'hF0; img[1] = 8'h0F; img[2] = 8'h33; img[3] = 8'h44;
    run_load(4, -1, 0, ab);
    chk("R7 error on status drop", load_err, 1);
    chk("R7 edges before abort", rises, 10);
    chk("R7 idle pins", {busy, cfg_n_o, dclk_o}, 3'b010);
    chk("R7 done low", load_done, 0);
  endtask

  task automatic t_done_timeout();
    bit ab;
    do_reset(5, 0, 0);
    img[0] = 8'h81; img[1] = 8'h7F;
    run_load(2, -1, 0, ab);
    chk("R9 error without complete", load_err, 1);
    chk("R9 trailing edges", rises - 16, DONE_LIMIT);
    chk("R9 done low", load_done, 0);
  endtask

  task automatic t_mid_start();
    bit ab;
    do_reset(5, 32, 0);
    img[0] = 8'h9A; img[1] = 8'hBC; img[2] = 8'hDE; img[3] = 8'hF1;
    run_load(4, 2, 0, ab);
    chk("R10 request pulses", falls, 1);
    chk("R10 image incl marked byte", img_mism(4), 0);
    chk("R10 done", load_done, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset_idle();
    t_normal();
    t_back_to_back();
    t_stall();
    t_status_timeout();
    t_drop();
    t_done_timeout();
    t_mid_start();
    finish_run();
  end
endmodule